// File: doc/BRIEF.md
# Parallel-Port System Control Glue

This block sits between the three byte-wide ports of a general-purpose parallel interface chip and the peripherals of a small computer board. It has four jobs. It latches the port A byte into a keyboard row select, a drive select and a printer strobe. It returns the selected keyboard row on port B. It takes a 3-bit memory bank number from the low bits of port C. It assembles a port C status byte from printer busy, motor feedback, carrier detect and write protect. The block also turns the floppy controller's data request and completion lines into the CPU's non-maskable and maskable interrupts.

Two small state machines carry the sequential behaviour. The drive picker holds `DRV_NONE`, `DRV_FIRST` or `DRV_SECOND`. A port A write moves it to `DRV_SECOND` when bit 5 is set, to `DRV_FIRST` when only bit 4 is set, and to `DRV_NONE` otherwise. Each drive has a motor latch that copies the timer's active-low motor line only while that drive is picked.

The interrupt sequencer has the states `NMI_IDLE`, `NMI_SKIP` and `NMI_HELD`. From `NMI_IDLE`, a request seen with the CPU halted goes to `NMI_HELD`, and a request seen without halt goes to `NMI_SKIP`. Both `NMI_SKIP` and `NMI_HELD` return to `NMI_IDLE` when the request drops. The non-maskable interrupt is high only in `NMI_HELD`.

Top module: `ppi_sys_glue`

## Requirements
- R1: After reset the keyboard row is 0, `drv_sel` is 00, `prn_strobe` is 0, `mem_bank` is 0, `cpu_nmi` is 0 and both `drv_motor_n` bits are 1.
- R2: A port A write (`pa_we`) with bits 3:0 equal to a row r from 0 to 9 makes `pb_rdata` equal to `key_cols_n[r*8+7 : r*8]`, starting in the cycle after the write clock edge.
- R3: A port A write with bits 3:0 from 10 to 15 makes `pb_rdata` read 0xFF whatever the matrix holds.
- R4: On a port A write, bit 5 set picks drive 1 (`drv_sel`=10) whatever bit 4 is. Bit 4 alone picks drive 0 (`drv_sel`=01). Neither bit set gives `drv_sel`=00.
- R5: `prn_strobe` follows port A bit 7 of the last write, and `pc_rdata[4]` equals `prn_busy`.
- R6: `pc_rdata[5]` is the inverse of `timer_motor_n` in the same cycle.
- R7: `pc_rdata[7]` equals `drv_wprot[0]` when drive 0 is picked, equals `drv_wprot[1]` when drive 1 is picked, and is 0 when no drive is picked.
- R8: At each clock edge where a drive is picked, that drive's `drv_motor_n` bit takes `timer_motor_n`. The other drive's bit holds its value.
- R9: The first cycle of a data request sampled with `cpu_halt` high raises `cpu_nmi` after that edge, and it stays high until the request drops. A request first sampled without halt gives no `cpu_nmi` until the request drops and rises again. A low request clears `cpu_nmi` after the next edge.
- R10: `cpu_irq` equals `fdc_intrq` in the same cycle.
- R11: A port C write (`pc_we`) loads `pc_lo_wdata[2:0]` into `mem_bank`. With no write, `mem_bank` holds.
- R12: `pc_rdata[3:0]` reads 0. `pc_rdata[6]` equals `carrier_det` when `CD_PRESENT` is 1 (the default) and reads 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_wdata | input | 8 | Port A byte from the interface chip |
| pa_we | input | 1 | Port A write strobe |
| pc_lo_wdata | input | 3 | Port C low bits (bank number) |
| pc_we | input | 1 | Port C write strobe |
| pb_rdata | output | 8 | Port B: active-low columns of the selected row |
| pc_rdata | output | 8 | Port C status byte |
| key_cols_n | input | 80 | Keyboard matrix, 10 rows of 8 active-low columns |
| drv_sel | output | 2 | Drive select, bit 0 for drive 0 |
| drv_motor_n | output | 2 | Per-drive active-low motor line |
| drv_wprot | input | 2 | Per-drive write-protect, high when protected |
| timer_motor_n | input | 1 | Active-low motor enable from timer channel 2 |
| prn_strobe | output | 1 | Printer strobe |
| prn_busy | input | 1 | Printer busy |
| carrier_det | input | 1 | Serial carrier detect |
| mem_bank | output | 3 | Memory bank register |
| fdc_drq | input | 1 | Floppy data request |
| fdc_intrq | input | 1 | Floppy completion interrupt |
| cpu_halt | input | 1 | CPU halt status |
| cpu_nmi | output | 1 | CPU non-maskable interrupt |
| cpu_irq | output | 1 | CPU maskable interrupt |

## Verification
The row select is swept over all sixteen values with a fresh random matrix each cycle. A wrong slice, an off-by-one row limit or a missing 0xFF fill gives a mismatch at once. All four combinations of the drive bits are written while the write-protect lines and the motor line toggle. This separates the priority order, the no-drive case and whether a deselected drive's motor latch holds. The request line is driven through three patterns: a rise while halted, a rise before halt with halt arriving later, and back-to-back pulses. These tell level-triggered behaviour apart from edge-armed behaviour. A long random phase then mixes every input against the reference model.

// File: rtl/ppi_glue_pkg.sv
package ppi_glue_pkg;

    // drive picker state
    typedef enum logic [1:0] {
        DRV_NONE   = 2'd0,
        DRV_FIRST  = 2'd1,
        DRV_SECOND = 2'd2
    } drv_pick_t;

    // data-request interrupt sequencer state
    typedef enum logic [1:0] {
        NMI_IDLE = 2'd0,
        NMI_SKIP = 2'd1,
        NMI_HELD = 2'd2
    } nmi_state_t;

    // port A field positions (decoded by the interface chip's neighbours)
    localparam int PA_DSEL0_BIT  = 4;
    localparam int PA_DSEL1_BIT  = 5;
    localparam int PA_STROBE_BIT = 7;

    // port C status positions
    localparam int PC_BUSY_BIT = 4;
    localparam int PC_MFB_BIT  = 5;
    localparam int PC_CD_BIT   = 6;
    localparam int PC_WP_BIT   = 7;

endpackage

// File: rtl/ppi_glue_kbd_mux.sv
module ppi_glue_kbd_mux #(
    parameter int ROWS      = 10,
    parameter int COLS      = 8,
    parameter int ROW_SEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   row_we,
    input  logic [ROW_SEL_W-1:0]   row_wdata,
    input  logic [ROWS*COLS-1:0]   key_cols_n,
    output logic [COLS-1:0]        col_n
);
    logic [ROW_SEL_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (row_we)
            row_q <= row_wdata;
    end

    // unselected or out-of-range row reads all ones (no key pressed)
    always_comb begin
        col_n = '1;
        for (int r = 0; r < ROWS; r++) begin
            if (row_q == ROW_SEL_W'(r))
                col_n = key_cols_n[r*COLS +: COLS];
        end
    end
endmodule

// File: rtl/ppi_glue_drive_ctl.sv
module ppi_glue_drive_ctl
    import ppi_glue_pkg::*;
#(
    parameter int NDRV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_we,
    input  logic [1:0]      sel_bits,
    input  logic            timer_motor_n,
    input  logic [NDRV-1:0] wprot,
    output logic [NDRV-1:0] drv_sel,
    output logic [NDRV-1:0] motor_n,
    output logic            wp_sel
);
    drv_pick_t pick_q, pick_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            pick_q <= DRV_NONE;
        else
            pick_q <= pick_d;
    end

    // next pick: the second drive's bit wins
    always_comb begin
        pick_d = pick_q;
        if (sel_we) begin
            if (sel_bits[1])
                pick_d = DRV_SECOND;
            else if (sel_bits[0])
                pick_d = DRV_FIRST;
            else
                pick_d = DRV_NONE;
        end
    end

    // outputs of the picked state
    always_comb begin
        drv_sel = '0;
        wp_sel  = 1'b0;
        unique case (pick_q)
            DRV_NONE: begin
                drv_sel = '0;
                wp_sel  = 1'b0;
            end
            DRV_FIRST: begin
                drv_sel[0] = 1'b1;
                wp_sel     = wprot[0];
            end
            DRV_SECOND: begin
                drv_sel[1] = 1'b1;
                wp_sel     = wprot[1];
            end
            default: begin
                drv_sel = '0;
                wp_sel  = 1'b0;
            end
        endcase
    end

    // per-drive motor latch, refreshed only while that drive is picked
    for (genvar d = 0; d < NDRV; d++) begin : g_motor
        always_ff @(posedge clk) begin
            if (!rst_n)
                motor_n[d] <= 1'b1;
            else if (drv_sel[d])
                motor_n[d] <= timer_motor_n;
        end
    end
endmodule

// File: rtl/ppi_glue_nmi_fsm.sv
module ppi_glue_nmi_fsm
    import ppi_glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drq,
    input  logic halt,
    output logic nmi
);
    nmi_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= NMI_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE: if (drq) state_d = halt ? NMI_HELD : NMI_SKIP;
            NMI_SKIP: if (!drq) state_d = NMI_IDLE;
            NMI_HELD: if (!drq) state_d = NMI_IDLE;
            default:  state_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            NMI_HELD: nmi = 1'b1;
            default:  nmi = 1'b0;
        endcase
    end
endmodule

// File: rtl/ppi_sys_glue.sv
module ppi_sys_glue
    import ppi_glue_pkg::*;
#(
    parameter int ROWS       = 10,
    parameter int PORT_W     = 8,
    parameter int ROW_SEL_W  = 4,
    parameter int BANK_W     = 3,
    parameter bit CD_PRESENT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORT_W-1:0]      pa_wdata,
    input  logic                   pa_we,
    input  logic [BANK_W-1:0]      pc_lo_wdata,
    input  logic                   pc_we,
    output logic [PORT_W-1:0]      pb_rdata,
    output logic [PORT_W-1:0]      pc_rdata,
    input  logic [ROWS*PORT_W-1:0] key_cols_n,
    output logic [1:0]             drv_sel,
    output logic [1:0]             drv_motor_n,
    input  logic [1:0]             drv_wprot,
    input  logic                   timer_motor_n,
    output logic                   prn_strobe,
    input  logic                   prn_busy,
    input  logic                   carrier_det,
    output logic [BANK_W-1:0]      mem_bank,
    input  logic                   fdc_drq,
    input  logic                   fdc_intrq,
    input  logic                   cpu_halt,
    output logic                   cpu_nmi,
    output logic                   cpu_irq
);
    localparam int LOW_ZERO_W = PC_BUSY_BIT;

    logic wp_sel;
    logic cd_bit;
    logic unused_pa6;

    assign unused_pa6 = pa_wdata[6];

    ppi_glue_kbd_mux #(
        .ROWS(ROWS), .COLS(PORT_W), .ROW_SEL_W(ROW_SEL_W)
    ) u_kbd (
        .clk(clk), .rst_n(rst_n),
        .row_we(pa_we), .row_wdata(pa_wdata[ROW_SEL_W-1:0]),
        .key_cols_n(key_cols_n), .col_n(pb_rdata)
    );

    ppi_glue_drive_ctl #(.NDRV(2)) u_drv (
        .clk(clk), .rst_n(rst_n),
        .sel_we(pa_we),
        .sel_bits({pa_wdata[PA_DSEL1_BIT], pa_wdata[PA_DSEL0_BIT]}),
        .timer_motor_n(timer_motor_n), .wprot(drv_wprot),
        .drv_sel(drv_sel), .motor_n(drv_motor_n), .wp_sel(wp_sel)
    );

    ppi_glue_nmi_fsm u_nmi (
        .clk(clk), .rst_n(rst_n),
        .drq(fdc_drq), .halt(cpu_halt), .nmi(cpu_nmi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prn_strobe <= 1'b0;
            mem_bank   <= '0;
        end else begin
            if (pa_we) prn_strobe <= pa_wdata[PA_STROBE_BIT];
            if (pc_we) mem_bank   <= pc_lo_wdata;
        end
    end

    if (CD_PRESENT) begin : g_cd
        assign cd_bit = carrier_det;
    end else begin : g_no_cd
        logic unused_cd;
        assign unused_cd = carrier_det;
        assign cd_bit    = 1'b0;
    end

    always_comb begin
        pc_rdata                 = '0;
        pc_rdata[LOW_ZERO_W-1:0] = '0;
        pc_rdata[PC_BUSY_BIT]    = prn_busy;
        pc_rdata[PC_MFB_BIT]     = ~timer_motor_n;
        pc_rdata[PC_CD_BIT]      = cd_bit;
        pc_rdata[PC_WP_BIT]      = wp_sel;
    end

    assign cpu_irq = fdc_intrq;
endmodule

// File: rtl/ppi_sys_glue_chk.sv
module ppi_sys_glue_chk #(
    parameter int ROWS = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pa_wdata,
    input logic       pa_we,
    input logic       pc_we,
    input logic [7:0] pb_rdata,
    input logic [7:0] pc_rdata,
    input logic [1:0] drv_sel,
    input logic [1:0] drv_motor_n,
    input logic       timer_motor_n,
    input logic [2:0] mem_bank,
    input logic       fdc_drq,
    input logic       fdc_intrq,
    input logic       cpu_halt,
    input logic       cpu_nmi,
    input logic       cpu_irq
);
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (pa_we && pa_wdata[3:0] >= 4'(ROWS)) |=> pb_rdata == 8'hFF); // R3
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drv_sel)); // R4
    AST_SEL_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) (pa_we && pa_wdata[5]) |=> drv_sel == 2'b10); // R4
    AST_MOTOR_FB: assert property (@(posedge clk) disable iff (!rst_n) pc_rdata[5] == !timer_motor_n); // R6
    AST_WP_NONE: assert property (@(posedge clk) disable iff (!rst_n) (drv_sel == 2'b00) |-> !pc_rdata[7]); // R7
    AST_MOTOR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) drv_sel[0] |=> drv_motor_n[0] == $past(timer_motor_n)); // R8
    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_nmi) |-> $past(fdc_drq && cpu_halt)); // R9
    AST_NMI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !fdc_drq |=> !cpu_nmi); // R9
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) cpu_irq == fdc_intrq); // R10
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pc_we |=> $stable(mem_bank)); // R11
endmodule

bind ppi_sys_glue ppi_sys_glue_chk #(.ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .pa_wdata(pa_wdata), .pa_we(pa_we), .pc_we(pc_we),
    .pb_rdata(pb_rdata), .pc_rdata(pc_rdata), .drv_sel(drv_sel),
    .drv_motor_n(drv_motor_n), .timer_motor_n(timer_motor_n), .mem_bank(mem_bank),
    .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq), .cpu_halt(cpu_halt),
    .cpu_nmi(cpu_nmi), .cpu_irq(cpu_irq)
);

// File: tb/ppi_sys_glue_test.sv
module ppi_sys_glue_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pa_wdata = '0;
    logic        pa_we = 1'b0;
    logic [2:0]  pc_lo_wdata = '0;
    logic        pc_we = 1'b0;
    logic [7:0]  pb_rdata, pc_rdata;
    logic [79:0] key_cols_n = '1;
    logic [1:0]  drv_sel, drv_motor_n;
    logic [1:0]  drv_wprot = '0;
    logic        timer_motor_n = 1'b1;
    logic        prn_strobe;
    logic        prn_busy = 1'b0;
    logic        carrier_det = 1'b0;
    logic [2:0]  mem_bank;
    logic        fdc_drq = 1'b0, fdc_intrq = 1'b0, cpu_halt = 1'b0;
    logic        cpu_nmi, cpu_irq;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_row, m_drv, m_strobe, m_bank, m_nmi_st;
    int m_mot0, m_mot1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppi_sys_glue uut (
        .clk(clk), .rst_n(rst_n), .pa_wdata(pa_wdata), .pa_we(pa_we),
        .pc_lo_wdata(pc_lo_wdata), .pc_we(pc_we), .pb_rdata(pb_rdata),
        .pc_rdata(pc_rdata), .key_cols_n(key_cols_n), .drv_sel(drv_sel),
        .drv_motor_n(drv_motor_n), .drv_wprot(drv_wprot),
        .timer_motor_n(timer_motor_n), .prn_strobe(prn_strobe),
        .prn_busy(prn_busy), .carrier_det(carrier_det), .mem_bank(mem_bank),
        .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq), .cpu_halt(cpu_halt),
        .cpu_nmi(cpu_nmi), .cpu_irq(cpu_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_row = 0; m_drv = 0; m_strobe = 0; m_bank = 0; m_nmi_st = 0;
            m_mot0 = 1; m_mot1 = 1;
        end else begin
            if (m_drv == 1) m_mot0 = int'(timer_motor_n);
            if (m_drv == 2) m_mot1 = int'(timer_motor_n);
            if (pa_we) begin
                m_row    = int'(pa_wdata[3:0]);
                m_drv    = pa_wdata[5] ? 2 : (pa_wdata[4] ? 1 : 0);
                m_strobe = int'(pa_wdata[7]);
            end
            if (pc_we) m_bank = int'(pc_lo_wdata);
            if (m_nmi_st == 0) begin
                if (fdc_drq) m_nmi_st = cpu_halt ? 2 : 1;
            end else if (!fdc_drq) begin
                m_nmi_st = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_pb, exp_wp;
        exp_pb = (m_row < ROWS) ? int'(key_cols_n[m_row*8 +: 8]) : 8'hFF;
        exp_wp = (m_drv == 1) ? int'(drv_wprot[0]) : ((m_drv == 2) ? int'(drv_wprot[1]) : 0);
        if (m_row < ROWS) chk("R2 port B row", int'(pb_rdata), exp_pb);
        else              chk("R3 port B out of range", int'(pb_rdata), exp_pb);
        chk("R4 drive select", int'(drv_sel), (m_drv == 2) ? 2 : ((m_drv == 1) ? 1 : 0));
        chk("R5 strobe", int'(prn_strobe), m_strobe);
        chk("R5 busy bit", int'(pc_rdata[4]), int'(prn_busy));
        chk("R6 motor feedback", int'(pc_rdata[5]), int'(!timer_motor_n));
        chk("R7 write protect", int'(pc_rdata[7]), exp_wp);
        chk("R8 motor lines", int'(drv_motor_n), m_mot1 * 2 + m_mot0);
        chk("R9 nmi", int'(cpu_nmi), (m_nmi_st == 2) ? 1 : 0);
        chk("R10 irq", int'(cpu_irq), int'(fdc_intrq));
        chk("R11 bank", int'(mem_bank), m_bank);
        chk("R12 carrier bit", int'(pc_rdata[6]), int'(carrier_det));
        chk("R12 low bits", int'(pc_rdata[3:0]), 0);
    endtask

    task automatic tick();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic write_pa(input logic [7:0] v);
        pa_wdata = v; pa_we = 1'b1;
        tick();
        pa_we = 1'b0;
    endtask

    task automatic rand_keys();
        key_cols_n = {$urandom, $urandom, $urandom};
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset drv_sel", int'(drv_sel), 0);
        chk("R1 reset strobe", int'(prn_strobe), 0);
        chk("R1 reset bank", int'(mem_bank), 0);
        chk("R1 reset nmi", int'(cpu_nmi), 0);
        chk("R1 reset motors", int'(drv_motor_n), 3);
        chk("R1 reset row0", int'(pb_rdata), int'(key_cols_n[7:0]));
        @(negedge clk);

        // R2 / R3: sweep all row codes
        for (int r = 0; r < 16; r++) begin
            rand_keys();
            write_pa(8'(r));
            rand_keys(); tick();
            rand_keys(); tick();
        end

        // R4 / R7 / R8: drive select combinations
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) begin
                drv_wprot = 2'(w);
                timer_motor_n = w[0];
                write_pa(8'(s << 4) | 8'h02);
                timer_motor_n = ~timer_motor_n;
                tick(); tick();
            end
        end
        // deselected drive holds its motor value
        write_pa(8'h10); timer_motor_n = 1'b0; tick(); tick();
        write_pa(8'h20); timer_motor_n = 1'b1; tick(); tick();
        write_pa(8'h00); timer_motor_n = 1'b0; tick(); tick();

        // R5: strobe and busy
        write_pa(8'h80); prn_busy = 1'b1; tick();
        write_pa(8'h00); prn_busy = 1'b0; tick();

        // R11: bank writes with and without strobe
        for (int b = 0; b < 8; b++) begin
            pc_lo_wdata = 3'(b); pc_we = 1'b1; tick();
            pc_we = 1'b0; pc_lo_wdata = 3'(~b); tick();
        end

        // R9: request rises while halted
        cpu_halt = 1'b1; fdc_drq = 1'b1; tick(); tick();
        cpu_halt = 1'b0; tick(); tick();
        fdc_drq = 1'b0; tick(); tick();
        // R9: request rises before halt, halt arrives later
        fdc_drq = 1'b1; tick(); cpu_halt = 1'b1; tick(); tick();
        fdc_drq = 1'b0; tick();
        fdc_drq = 1'b1; tick(); tick();
        fdc_drq = 1'b0; tick();
        // back-to-back pulses while halted
        for (int p = 0; p < 4; p++) begin
            fdc_drq = 1'b1; tick();
            fdc_drq = 1'b0; tick();
        end
        cpu_halt = 1'b0;

        // R10 / R12
        fdc_intrq = 1'b1; carrier_det = 1'b1; tick();
        fdc_intrq = 1'b0; carrier_det = 1'b0; tick();

        // random phase
        for (int i = 0; i < 2000; i++) begin
            pa_wdata      = 8'($urandom);
            pa_we         = ($urandom_range(0, 3) == 0);
            pc_lo_wdata   = 3'($urandom);
            pc_we         = ($urandom_range(0, 3) == 0);
            drv_wprot     = 2'($urandom);
            timer_motor_n = 1'($urandom);
            prn_busy      = 1'($urandom);
            carrier_det   = 1'($urandom);
            fdc_intrq     = 1'($urandom);
            cpu_halt      = 1'($urandom);
            if ($urandom_range(0, 2) == 0) fdc_drq = ~fdc_drq;
            if ($urandom_range(0, 7) == 0) rand_keys();
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule